// File: doc/BRIEF.md
# Load Data Extension Unit

This block shapes the word returned by memory for a load before it reaches a 32-bit destination register. From the load-type code and the two low address bits it picks a byte or halfword lane out of the memory word. It then widens that lane to 32 bits, either by copying its top bit upward or by padding with zeros. A word load passes through untouched.

A separate select bit steers the write to register file A or file B. Unused type codes block the write and raise an illegal flag. Halfword and word accesses on an address that does not fit their size raise a misalignment flag but are otherwise carried out as usual. Every result is registered with one cycle of latency and comes out with a valid strobe.

Top module: `load_extend_unit`

## Requirements
- R1: Type code 3'b010 (signed byte) yields the chosen byte in bits [7:0] and copies of its bit 7 in bits [31:8].
- R2: Type code 3'b001 (unsigned byte) yields the chosen byte in bits [7:0] and zeros in bits [31:8].
- R3: Type code 3'b100 (signed halfword) yields the chosen halfword in bits [15:0] and copies of its bit 15 in bits [31:16].
- R4: Type code 3'b000 (unsigned halfword) yields the chosen halfword in bits [15:0] and zeros in bits [31:16].
- R5: Type code 3'b110 (word) yields the memory word unchanged.
- R6: Lanes are little-endian: address bits [1:0] = n select byte bits [8n+7:8n], and address bit 1 selects the halfword, 0 for bits [15:0] and 1 for bits [31:16].
- R7: The file output equals the select input of the same access (0 means file A, 1 means file B), whatever the type code.
- R8: Type codes 3'b011, 3'b101 and 3'b111 give write enable 0, illegal flag 1 and a zero result.
- R9: The misalignment flag is 1 for a halfword type with address bit 0 set, or a word type with either low address bit set, and 0 otherwise; a misaligned legal access is still written.
- R10: Outputs appear on the clock edge after the input is taken; valid follows the input valid with one cycle of delay, and while it is 0 write enable, illegal and misalignment flags are 0.
- R11: While reset is held, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load's data is present this cycle |
| ld_type | input | 3 | Load-type code |
| mem_word | input | 32 | Word read from memory |
| addr_lo | input | 2 | Low two address bits |
| file_sel | input | 1 | Destination file select, 0 for A, 1 for B |
| res_data | output | 32 | Extended result |
| res_file_b | output | 1 | Result goes to file B when 1, file A when 0 |
| res_we | output | 1 | Register write enable |
| res_valid | output | 1 | Outputs carry a result this cycle |
| res_illegal | output | 1 | Type code was not a defined load |
| res_misalign | output | 1 | Halfword or word address was misaligned |

## Verification
The hardest case to provoke is a misaligned access, where lane selection still has to produce a defined halfword from the upper address bit while the flag is raised and the write stays enabled. The vector table places each halfword and word type against odd and off-word addresses with a memory word whose lanes all differ and whose sign bits alternate, so a wrong lane, a wrong fill or a suppressed write shows up in the data. Unused codes are mixed with both file selects so that a leaked write or stale data is visible.

// File: rtl/load_extend_unit.sv
module load_extend_unit #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    ld_type,
  input  logic [DW-1:0] mem_word,
  input  logic [1:0]    addr_lo,
  input  logic          file_sel,
  output logic [DW-1:0] res_data,
  output logic          res_file_b,
  output logic          res_we,
  output logic          res_valid,
  output logic          res_illegal,
  output logic          res_misalign
);

  localparam logic [2:0] T_HALF_U = 3'b000;
  localparam logic [2:0] T_BYTE_U = 3'b001;
  localparam logic [2:0] T_BYTE_S = 3'b010;
  localparam logic [2:0] T_HALF_S = 3'b100;
  localparam logic [2:0] T_WORD   = 3'b110;

  logic [7:0]    lane_b;
  logic [15:0]   lane_h;
  logic [DW-1:0] ext;
  logic          bad_type;
  logic          mis;

  assign lane_b = mem_word[{addr_lo, 3'b000} +: 8];
  assign lane_h = addr_lo[1] ? mem_word[31:16] : mem_word[15:0];

  always_comb begin
    ext      = '0;
    bad_type = 1'b0;
    mis      = 1'b0;
    case (ld_type)
      T_BYTE_S: ext = {{(DW-8){lane_b[7]}}, lane_b};
      T_BYTE_U: ext = {{(DW-8){1'b0}}, lane_b};
      T_HALF_S: begin
        ext = {{(DW-16){lane_h[15]}}, lane_h};
        mis = addr_lo[0];
      end
      T_HALF_U: begin
        ext = {{(DW-16){1'b0}}, lane_h};
        mis = addr_lo[0];
      end
      T_WORD: begin
        ext = mem_word;
        mis = |addr_lo;
      end
      default: bad_type = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data     <= '0;
      res_file_b   <= 1'b0;
      res_we       <= 1'b0;
      res_valid    <= 1'b0;
      res_illegal  <= 1'b0;
      res_misalign <= 1'b0;
    end else begin
      res_valid    <= in_valid;
      res_data     <= in_valid ? ext : '0;
      res_file_b   <= in_valid & file_sel;
      res_we       <= in_valid & ~bad_type;
      res_illegal  <= in_valid & bad_type;
      res_misalign <= in_valid & mis;
    end
  end

  // R8
  we_vs_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_we != res_illegal));

  // R8
  illegal_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_illegal |-> (res_data == '0));

  // R10
  valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (res_valid == $past(in_valid)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> !(res_we | res_illegal | res_misalign));

  // R9
  misalign_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_misalign |-> (res_we && !res_illegal));

endmodule

// File: tb/load_extend_unit_tb.sv
module load_extend_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 20;

  // {type, addr, sel, word, exp_data, exp_we, exp_ill, exp_mis}
  localparam logic [72:0] VEC [NV] = '{
    {3'b010, 2'd0, 1'b0, 32'h80F47F81, 32'hFFFFFF81, 1'b1, 1'b0, 1'b0},
    {3'b010, 2'd1, 1'b1, 32'h80F47F81, 32'h0000007F, 1'b1, 1'b0, 1'b0},
    {3'b010, 2'd2, 1'b0, 32'h80F47F81, 32'hFFFFFFF4, 1'b1, 1'b0, 1'b0},
    {3'b010, 2'd3, 1'b1, 32'h80F47F81, 32'hFFFFFF80, 1'b1, 1'b0, 1'b0},
    {3'b001, 2'd0, 1'b0, 32'h80F47F81, 32'h00000081, 1'b1, 1'b0, 1'b0},
    {3'b001, 2'd2, 1'b1, 32'h80F47F81, 32'h000000F4, 1'b1, 1'b0, 1'b0},
    {3'b001, 2'd3, 1'b0, 32'h80F47F81, 32'h00000080, 1'b1, 1'b0, 1'b0},
    {3'b001, 2'd1, 1'b1, 32'h12345678, 32'h00000056, 1'b1, 1'b0, 1'b0},
    {3'b100, 2'd0, 1'b0, 32'h80F47F81, 32'h00007F81, 1'b1, 1'b0, 1'b0},
    {3'b100, 2'd2, 1'b1, 32'h80F47F81, 32'hFFFF80F4, 1'b1, 1'b0, 1'b0},
    {3'b000, 2'd2, 1'b0, 32'h80F47F81, 32'h000080F4, 1'b1, 1'b0, 1'b0},
    {3'b000, 2'd0, 1'b1, 32'h80F47F81, 32'h00007F81, 1'b1, 1'b0, 1'b0},
    {3'b110, 2'd0, 1'b1, 32'h80F47F81, 32'h80F47F81, 1'b1, 1'b0, 1'b0},
    {3'b100, 2'd1, 1'b0, 32'h80F47F81, 32'h00007F81, 1'b1, 1'b0, 1'b1},
    {3'b000, 2'd3, 1'b1, 32'h80F47F81, 32'h000080F4, 1'b1, 1'b0, 1'b1},
    {3'b110, 2'd2, 1'b0, 32'h80F47F81, 32'h80F47F81, 1'b1, 1'b0, 1'b1},
    {3'b110, 2'd1, 1'b1, 32'h12345678, 32'h12345678, 1'b1, 1'b0, 1'b1},
    {3'b011, 2'd0, 1'b1, 32'h80F47F81, 32'h00000000, 1'b0, 1'b1, 1'b0},
    {3'b101, 2'd1, 1'b0, 32'h80F47F81, 32'h00000000, 1'b0, 1'b1, 1'b0},
    {3'b111, 2'd3, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  ld_type = 3'b000;
  logic [31:0] mem_word = '0;
  logic [1:0]  addr_lo = '0;
  logic        file_sel = 1'b0;
  logic [31:0] res_data;
  logic        res_file_b, res_we, res_valid, res_illegal, res_misalign;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  load_extend_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .ld_type(ld_type),
    .mem_word(mem_word), .addr_lo(addr_lo), .file_sel(file_sel),
    .res_data(res_data), .res_file_b(res_file_b), .res_we(res_we),
    .res_valid(res_valid), .res_illegal(res_illegal), .res_misalign(res_misalign)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic string type_tag(input logic [2:0] t);
    case (t)
      3'b010:  return "R1 signed byte";
      3'b001:  return "R2 unsigned byte";
      3'b100:  return "R3 signed half";
      3'b000:  return "R4 unsigned half";
      3'b110:  return "R5 word";
      default: return "R8 illegal code";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11 data", res_data, 32'h0);
    check("R11 flags", {27'b0, res_file_b, res_we, res_valid, res_illegal, res_misalign}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      {ld_type, addr_lo, file_sel, mem_word} = VEC[i][72:35];
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("%s R6 v%0d data", type_tag(VEC[i][72:70]), i), res_data, VEC[i][34:3]);
      check($sformatf("R8 v%0d we", i), {31'b0, res_we}, {31'b0, VEC[i][2]});
      check($sformatf("R8 v%0d illegal", i), {31'b0, res_illegal}, {31'b0, VEC[i][1]});
      check($sformatf("R9 v%0d misalign", i), {31'b0, res_misalign}, {31'b0, VEC[i][0]});
      check($sformatf("R7 v%0d file", i), {31'b0, res_file_b}, {31'b0, VEC[i][67]});
      check($sformatf("R10 v%0d valid", i), {31'b0, res_valid}, 32'h1);
    end

    // R10: no input valid -> quiet outputs, even with a misaligned illegal-looking input
    in_valid = 1'b0; ld_type = 3'b111; addr_lo = 2'd1; file_sel = 1'b1;
    @(negedge clk);
    check("R10 idle flags", {27'b0, res_file_b, res_we, res_valid, res_illegal, res_misalign}, 32'h0);

    // R10: one-cycle latency, output held off until the edge
    in_valid = 1'b1; ld_type = 3'b110; addr_lo = 2'd0; file_sel = 1'b0; mem_word = 32'hCAFE0123;
    #1;
    check("R10 before edge", {31'b0, res_valid}, 32'h0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 after edge data", res_data, 32'hCAFE0123);
    @(negedge clk);
    check("R10 pulse ends", {31'b0, res_valid}, 32'h0);

    // R7: B select then A select with identical data
    in_valid = 1'b1; ld_type = 3'b010; addr_lo = 2'd3; file_sel = 1'b1; mem_word = 32'h7F000000;
    @(negedge clk);
    check("R7 file B", {31'b0, res_file_b}, 32'h1);
    check("R1 positive byte", res_data, 32'h0000007F);
    file_sel = 1'b0;
    @(negedge clk);
    check("R7 file A", {31'b0, res_file_b}, 32'h0);

    // R11: reset mid-stream clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset again", {27'b0, res_file_b, res_we, res_valid, res_illegal, res_misalign}, 32'h0);
    check("R11 reset data", res_data, 32'h0);
    in_valid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule